// File: doc/BRIEF.md
# Instruction packet fetch sequencer

This block sits at the front of a small stack processor whose program memory is a synchronous block RAM with 18-bit words. Each word is a packet. A 2-bit qualifier at the top of the packet says how to read the other 16 bits. A qualifier of zero means the 16 bits are four 4-bit instructions, executed from the most significant nibble down. Any other qualifier means the 16 bits are an absolute packet address for a conditional jump, a jump or a call. The sequencer owns the program counter and the packet register. It presents the current instruction to the execute unit and redirects the fetch stream on control transfers and returns.

The RAM answers one cycle after the address is presented, so every packet fetch takes two cycles. The sequencer hides that latency where it can. The fetch for the next packet starts in the same cycle as the last real instruction of the current packet, unless that instruction needs the memory port. Inline literals live in the word after their packet, and the program counter steps over them as they are consumed.

Top module: `pkt_fetch_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the packet register is all zero and the program counter is 0. That first cycle therefore issues a packet fetch from address 0, with `op_issue` high and `op` = 0.
- R2: Within a packet, bits 17:16 are the qualifier and bits 15:12 are the leading instruction slot. When the qualifier is 0 and the sequencer is running, `op_issue` is high and `op` shows bits 15:12 of the packet register.
- R3: Retiring a sequential instruction moves slots 2, 3 and 4 (bits 11:8, 7:4, 3:0) up by one place and puts 0 (nop) in slot 4. The qualifier is left unchanged.
- R4: A packet with a nonzero qualifier retires whole in one cycle, with `op_issue` low and `ctl_req` equal to the qualifier. In that cycle the block fetches the target in bits 15:0. The exception is qualifier 1 (jump if zero) with `tos_zero` low, which fetches the next sequential packet instead. For qualifier 3 (call), `link_addr` carries the address of the word after the call packet.
- R5: Opcode 0xF (return) fetches the packet at `ret_addr` in the same cycle and drops any slots left behind it.
- R6: Each memory request sets the program counter to the requested address plus one. Opcode 0x1 (inline literal) reads the word at the program counter, so each literal consumes the next sequential word.
- R7: The packet requested in one cycle is loaded at the end of the following cycle. During that cycle there is no issue, no request and no `ctl_req`.
- R8: When slot 1 holds an opcode other than 0x1, 0x2, 0x3 or 0xF and slots 2 to 4 are all nop, the next sequential packet fetch is issued in the same cycle as that instruction.
- R9: When the last non-nop instruction is 0x1, 0x2 or 0x3, no packet fetch is issued in its cycle. The fetch is issued later, from the resulting all-nop packet.
- R10: Opcodes 0x1 and 0x2 take two cycles. In the cycle after they issue, there is no issue and no memory request.
- R11: A nop that has a non-nop behind it in the packet takes one cycle. A packet of all nops takes two cycles from its first cycle to the next packet's first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rd | output | 1 | Read request to program RAM this cycle |
| mem_addr | output | 16 | Word address of the read request |
| mem_rdata | input | 18 | RAM read data, valid the cycle after the request |
| tos_zero | input | 1 | Top of data stack is zero (jump-if-zero condition) |
| ret_addr | input | 16 | Top of return stack, the target of a return |
| op_issue | output | 1 | `op` is retired to the execute unit this cycle |
| op | output | 4 | Current slot-1 opcode |
| ctl_req | output | 2 | Control transfer retired this cycle: 0 none, 1 jump if zero, 2 jump, 3 call |
| link_addr | output | 16 | Return address to push on a call |

## Verification
On every cycle, the assertions check that each memory request leaves the program counter one past the requested address, and that a load or literal hold cycle stays quiet. They also check that a retired sequential slot moves the remaining slots up with nop fill, and that a control transfer is followed by a load cycle. Other properties need a whole program running through the bench's reference model. These are the exact cycle in which the overlapped fetch starts or is held back by a memory opcode, the literal skip landing on the right packet, the jump-if-zero choice following `tos_zero`, and return and call link values lining up.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  // Slot opcodes the sequencer itself must recognise
  localparam int OP_NOP   = 0;
  localparam int OP_LIT   = 1;
  localparam int OP_LOAD  = 2;
  localparam int OP_STORE = 3;
  localparam int OP_RET   = 15;

  // Qualifier codes
  localparam int Q_SEQ  = 0;
  localparam int Q_JZ   = 1;
  localparam int Q_JMP  = 2;
  localparam int Q_CALL = 3;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,   // packet register valid, slot 1 executes
    ST_LOAD = 2'd1,   // fetch in flight, RAM data captured at end of cycle
    ST_HOLD = 2'd2    // second cycle of a memory-reading opcode
  } seq_state_t;

endpackage

// File: rtl/fseq_decode.sv
module fseq_decode
  import fseq_pkg::*;
#(
  parameter int QUAL_W  = 2,
  parameter int SLOT_W  = 4,
  parameter int N_SLOTS = 4,
  localparam int ADDR_W = SLOT_W * N_SLOTS,
  localparam int PKT_W  = QUAL_W + ADDR_W
) (
  input  logic [PKT_W-1:0]  pkt,
  output logic              xfer,
  output logic [QUAL_W-1:0] qual,
  output logic [SLOT_W-1:0] op,
  output logic [ADDR_W-1:0] target,
  output logic              tail_empty,
  output logic              is_lit,
  output logic              is_load,
  output logic              is_store,
  output logic              is_ret
);

  logic [N_SLOTS-1:0] occupied;

  assign qual   = pkt[PKT_W-1 -: QUAL_W];
  assign target = pkt[ADDR_W-1:0];
  assign op     = pkt[ADDR_W-1 -: SLOT_W];
  assign xfer   = |qual;

  // slot 1 is the one executing; only the trailing slots matter here
  assign occupied[0] = 1'b0;
  for (genvar i = 1; i < N_SLOTS; i++) begin : g_occ
    assign occupied[i] = |pkt[ADDR_W-1-i*SLOT_W -: SLOT_W];
  end

  assign tail_empty = ~|occupied;
  assign is_lit     = !xfer && (op == SLOT_W'(OP_LIT));
  assign is_load    = !xfer && (op == SLOT_W'(OP_LOAD));
  assign is_store   = !xfer && (op == SLOT_W'(OP_STORE));
  assign is_ret     = !xfer && (op == SLOT_W'(OP_RET));

endmodule

// File: rtl/fseq_pkt_reg.sv
module fseq_pkt_reg #(
  parameter int QUAL_W  = 2,
  parameter int SLOT_W  = 4,
  parameter int N_SLOTS = 4,
  localparam int ADDR_W = SLOT_W * N_SLOTS,
  localparam int PKT_W  = QUAL_W + ADDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [PKT_W-1:0] din,
  output logic [PKT_W-1:0] q
);

  logic [PKT_W-1:0] shifted;

  // qualifier stays in place while instruction slots move up
  assign shifted[PKT_W-1 -: QUAL_W] = q[PKT_W-1 -: QUAL_W];
  for (genvar i = 0; i < N_SLOTS - 1; i++) begin : g_move
    assign shifted[ADDR_W-1-i*SLOT_W -: SLOT_W] = q[ADDR_W-1-(i+1)*SLOT_W -: SLOT_W];
  end
  assign shifted[SLOT_W-1:0] = '0;

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= shifted;
  end

endmodule

// File: rtl/fseq_pc.sv
module fseq_pc #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] pc
);

  // every memory request leaves the counter just past the word it read
  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (step) pc <= base + ADDR_W'(1);
  end

endmodule

// File: rtl/pkt_fetch_seq.sv
module pkt_fetch_seq
  import fseq_pkg::*;
#(
  parameter int QUAL_W  = 2,
  parameter int SLOT_W  = 4,
  parameter int N_SLOTS = 4,
  localparam int ADDR_W = SLOT_W * N_SLOTS,
  localparam int PKT_W  = QUAL_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [PKT_W-1:0]  mem_rdata,
  input  logic              tos_zero,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic              op_issue,
  output logic [SLOT_W-1:0] op,
  output logic [QUAL_W-1:0] ctl_req,
  output logic [ADDR_W-1:0] link_addr
);

  seq_state_t        st, st_nxt;
  logic [PKT_W-1:0]  pkt;
  logic [ADDR_W-1:0] pc;
  logic              pkt_load, pkt_shift;

  logic              d_xfer, d_tail_empty, d_lit, d_load, d_store, d_ret;
  logic [QUAL_W-1:0] d_qual;
  logic [ADDR_W-1:0] d_target;

  fseq_decode #(.QUAL_W(QUAL_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_dec (
    .pkt        (pkt),
    .xfer       (d_xfer),
    .qual       (d_qual),
    .op         (op),
    .target     (d_target),
    .tail_empty (d_tail_empty),
    .is_lit     (d_lit),
    .is_load    (d_load),
    .is_store   (d_store),
    .is_ret     (d_ret)
  );

  fseq_pkt_reg #(.QUAL_W(QUAL_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_pkt (
    .clk   (clk),
    .rst   (rst),
    .load  (pkt_load),
    .shift (pkt_shift),
    .din   (mem_rdata),
    .q     (pkt)
  );

  fseq_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk  (clk),
    .rst  (rst),
    .step (mem_rd),
    .base (mem_addr),
    .pc   (pc)
  );

  assign link_addr = pc;

  always_comb begin
    st_nxt    = st;
    mem_rd    = 1'b0;
    mem_addr  = pc;
    op_issue  = 1'b0;
    ctl_req   = '0;
    pkt_load  = 1'b0;
    pkt_shift = 1'b0;
    unique case (st)
      ST_RUN: begin
        if (d_xfer) begin
          ctl_req = d_qual;
          mem_rd  = 1'b1;
          if (!(d_qual == QUAL_W'(Q_JZ) && !tos_zero)) mem_addr = d_target;
          st_nxt  = ST_LOAD;
        end else begin
          op_issue = 1'b1;
          if (d_ret) begin
            mem_rd   = 1'b1;
            mem_addr = ret_addr;
            st_nxt   = ST_LOAD;
          end else if (d_lit) begin
            mem_rd    = 1'b1;
            pkt_shift = 1'b1;
            st_nxt    = ST_HOLD;
          end else if (d_load) begin
            pkt_shift = 1'b1;
            st_nxt    = ST_HOLD;
          end else if (d_tail_empty && !d_store) begin
            mem_rd    = 1'b1;
            pkt_shift = 1'b1;
            st_nxt    = ST_LOAD;
          end else begin
            pkt_shift = 1'b1;
          end
        end
      end
      ST_LOAD: begin
        pkt_load = 1'b1;
        st_nxt   = ST_RUN;
      end
      default: st_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_RUN;
    else     st <= st_nxt;
  end

  // R1: first cycle out of reset fetches packet 0
  a_r1_reset_fetch: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mem_rd && mem_addr == '0));

  // R3: slot shift with nop fill, qualifier kept
  a_r3_shift_up: assert property (@(posedge clk) disable iff (rst)
    pkt_shift |=> (pkt[ADDR_W-1:SLOT_W] == $past(pkt[ADDR_W-SLOT_W-1:0]))
                  && (pkt[SLOT_W-1:0] == '0)
                  && (pkt[PKT_W-1 -: QUAL_W] == $past(pkt[PKT_W-1 -: QUAL_W])));

  // R4: a retired transfer is always followed by a load cycle
  a_r4_xfer_then_load: assert property (@(posedge clk) disable iff (rst)
    (ctl_req != '0) |=> (st == ST_LOAD && !op_issue));

  // R6: program counter lands one past each requested word
  a_r6_pc_after_req: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> (pc == $past(mem_addr) + ADDR_W'(1)));

  // R7: load cycle is quiet and preceded by a request
  a_r7_load_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOAD) |-> (!mem_rd && !op_issue && ctl_req == '0 && $past(mem_rd)));

  // R10: hold cycle after a memory-reading opcode is quiet
  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD) |-> (!mem_rd && !op_issue && ctl_req == '0));

endmodule

// File: tb/tb_pkt_fetch_seq.sv
module tb_pkt_fetch_seq;

  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 4000;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [17:0] mem_rdata = '0;
  logic        tos_zero = 1'b0;
  logic [15:0] ret_addr = 16'd6;
  logic        op_issue;
  logic [3:0]  op;
  logic [1:0]  ctl_req;
  logic [15:0] link_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_fetch_seq dut (
    .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .tos_zero(tos_zero), .ret_addr(ret_addr),
    .op_issue(op_issue), .op(op), .ctl_req(ctl_req), .link_addr(link_addr)
  );

  logic [17:0] mem [256];

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  int checks = 0, failures = 0;
  bit finished = 0;

  function automatic logic [17:0] pk(int q, int a, int b, int c, int d);
    return {2'(q), 4'(a), 4'(b), 4'(c), 4'(d)};
  endfunction
  function automatic logic [17:0] pkj(int q, int t);
    return {2'(q), 16'(t)};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model state
  int m_mode, m_pc, m_q, m_pend;
  int sl[4];
  int n_call, n_jz_t, n_jz_n, n_ret, n_lit, n_ovl, n_nop2;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0]  = pk(0, 'hB, 'h1, 'hC, 0);
    mem[1]  = pkj(2, 'h00FF);          // literal word, looks like a jump
    mem[2]  = pk(0, 0, 0, 'h4, 0);
    mem[3]  = pk(0, 'h2, 0, 0, 0);
    mem[4]  = pk(0, 0, 0, 0, 0);
    mem[5]  = pkj(3, 'h0010);
    mem[6]  = pkj(1, 'h0020);
    mem[7]  = pk(0, 'hE, 'hD, 'hA, 'h9);
    mem[8]  = pk(0, 'h7, 'h8, 'h1, 0);
    mem[9]  = 18'h3ABCD;
    mem[10] = pkj(2, 0);
    mem[16] = pk(0, 'h5, 'hF, 'h6, 0);
    mem[32] = pk(0, 'h3, 0, 0, 0);
    mem[33] = pk(0, 'h1, 'h1, 0, 0);
    mem[34] = 18'h11111;
    mem[35] = 18'h22222;
    mem[36] = pkj(2, 0);

    m_mode = 0; m_pc = 0; m_q = 0; m_pend = 0;
    for (int i = 0; i < 4; i++) sl[i] = 0;

    repeat (3) @(posedge clk);
    // R1: outputs during reset
    @(negedge clk);
    check(op_issue == 1'b1 && op == 4'd0 && mem_addr == 16'd0, "R1", "reset state",
          {op_issue, op, mem_addr}, {1'b1, 4'd0, 16'd0});
    rst = 1'b0;

    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      int e_rd, e_addr, e_iss, e_op, e_ctl, e_link, rest, tgt;
      string tag;
      if (cyc > 0) @(negedge clk);
      tos_zero = 1'($urandom % 2);
      #1;
      e_rd = 0; e_addr = 0; e_iss = 0; e_op = 0; e_ctl = 0; e_link = m_pc;
      tag = (cyc == 0) ? "R1" : "R7";
      case (m_mode)
        0: begin
          if (m_q != 0) begin
            tgt = (sl[0] << 12) | (sl[1] << 8) | (sl[2] << 4) | sl[3];
            e_ctl = m_q; e_rd = 1; tag = "R4";
            e_addr = (m_q == 1 && !tos_zero) ? m_pc : tgt;
            if (m_q == 3) n_call++;
            if (m_q == 1) begin if (tos_zero) n_jz_t++; else n_jz_n++; end
            m_mode = 1;
          end else begin
            e_iss = 1; e_op = sl[0];
            rest = sl[1] | sl[2] | sl[3];
            if (sl[0] == 15) begin
              e_rd = 1; e_addr = ret_addr; tag = "R5"; n_ret++; m_mode = 1;
            end else if (sl[0] == 1) begin
              e_rd = 1; e_addr = m_pc; tag = "R6"; n_lit++; m_mode = 2;
            end else if (sl[0] == 2) begin
              tag = "R10"; m_mode = 2;
            end else if (sl[0] != 3 && rest == 0) begin
              e_rd = 1; e_addr = m_pc; m_mode = 1;
              if (sl[0] == 0) begin tag = (cyc == 0) ? "R1" : "R11"; n_nop2++; end
              else begin tag = "R8"; n_ovl++; end
            end else begin
              tag = (sl[0] == 3) ? "R9" : (sl[0] == 0 ? "R11" : "R3");
            end
            if (m_mode != 1 || e_rd == 1) begin
              sl[0] = sl[1]; sl[1] = sl[2]; sl[2] = sl[3]; sl[3] = 0;
            end
          end
          if (e_rd) begin m_pend = e_addr; m_pc = (e_addr + 1) & 'hFFFF; end
        end
        1: begin
          m_q = int'(mem[m_pend[7:0]][17:16]);
          for (int i = 0; i < 4; i++) sl[i] = int'(mem[m_pend[7:0]][15-4*i -: 4]);
          m_mode = 0;
        end
        default: begin
          tag = "R10"; m_mode = 0;
        end
      endcase

      if (e_iss) check(op_issue && op == 4'(e_op), (tag == "R10" || tag == "R9") ? tag : "R2",
                       "issued opcode", {op_issue, op}, {1'b1, 4'(e_op)});
      else       check(!op_issue, tag, "no issue", op_issue, 0);
      check(mem_rd == 1'(e_rd) && (!e_rd || mem_addr == 16'(e_addr)), tag, "memory request",
            {mem_rd, mem_addr}, {1'(e_rd), 16'(e_addr)});
      check(ctl_req == 2'(e_ctl), tag, "transfer request", ctl_req, e_ctl);
      if (e_ctl == 3) check(link_addr == 16'(e_link), "R4", "call link", link_addr, e_link);
    end

    check(n_call > 0 && n_jz_t > 0 && n_jz_n > 0, "R4", "transfer coverage", n_jz_n, 1);
    check(n_ret > 0, "R5", "return coverage", n_ret, 1);
    check(n_lit > 0, "R6", "literal coverage", n_lit, 1);
    check(n_ovl > 0, "R8", "overlap coverage", n_ovl, 1);
    check(n_nop2 > 0, "R11", "all-nop coverage", n_nop2, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, RUN_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule